// File: doc/BRIEF.md
# Latched Hexadecimal Seven-Segment Digit Driver

This block drives one digit of a seven-segment display from a 4-bit code. A clocked input register stands in for a transparent latch. While the hold input is low, the register takes a new code on every rising clock edge. While hold is high, it keeps the last code it took. The held code is decoded into seven active-low segment drives. All sixteen values have a glyph: the numerals 0 to 9 and the letters A, b, C, d, E, F. The two lower-case letters keep b and d from looking like 8 and 0.

Digits can be chained to suppress leading or trailing zeros. Each digit has an active-low ripple-blank input and an active-low ripple-blank output. When the input is asserted and the held code is zero, the digit goes dark and asserts its output towards the next digit in the chain. In a chain, the first digit has its input tied low. The units digit of the integer part has its input held high, so that it always shows its zero. A separate dark override turns every segment off and leaves the ripple output untouched. It can carry a pulse-width signal to dim the display.

Top module: `hex_digit_driver`

## Requirements
- R1: After synchronous reset the held code is 0. With ripple-blank input high and dark override low, seg_n then shows the zero glyph (7'h40) and rbo_n is high.
- R2: seg_n is active low, bit 0 = segment a through bit 6 = segment g. The lit-segment sets (active high, g..a) for codes 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R3: Codes 10 to 15 show A, b, C, d, E, F with lit sets 77, 7C, 39, 5E, 79, 71.
- R4: While hold is low, each rising clock edge loads code_in into the held code, and the outputs reflect it right after that edge.
- R5: While hold is high, changes on code_in have no effect. The held code and the outputs keep the value they had before hold rose.
- R6: When rbi_n is low and the held code is 0, all segments are off (seg_n = 7'h7F) and rbo_n is low.
- R7: When rbi_n is high and the held code is 0, the zero glyph is shown (if not forced dark) and rbo_n is high.
- R8: rbo_n is low only when rbi_n is low and the held code is 0. A nonzero code with rbi_n low is displayed normally, with rbo_n high.
- R9: While force_dark is high, seg_n = 7'h7F for every code. rbo_n still follows R6 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | 4 | Binary code to display |
| hold | input | 1 | High keeps the held code; low loads code_in each edge |
| rbi_n | input | 1 | Ripple-blank input, active low |
| force_dark | input | 1 | Turns every segment off while high |
| seg_n | output | 7 | Segment drives a..g, active low |
| rbo_n | output | 1 | Ripple-blank output, active low |

## Verification
The assertions assume that hold, code_in, rbi_n and force_dark are synchronous to clk and settle well before each rising edge. They also assume that the held code is defined only from the first edge after reset. The bench changes every input on the falling edge and samples the outputs one nanosecond after the rising edge. Reset is asserted from time zero. Random draws choose each input from its full range, and rbi_n is weighted low often enough to reach the zero-suppression case many times.

// File: rtl/hexdisp_pkg.sv
package hexdisp_pkg;

    localparam int CODE_W = 4;
    localparam int SEG_W  = 7;
    localparam int N_CODE = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEG_W-1:0]  seg_t;

    // Why the digit is dark, if it is
    typedef enum logic [1:0] {
        BLK_NONE   = 2'd0,
        BLK_RIPPLE = 2'd1,
        BLK_FORCE  = 2'd2
    } blank_why_e;

    typedef struct packed {
        blank_why_e why;
        logic       ripple_n;   // active-low ripple status for the next digit
    } blank_dec_t;

    // Lit segments, active high, bit 0 = a ... bit 6 = g
    function automatic seg_t glyph_lit(input code_t c);
        seg_t s;
        case (c)
            4'h0: s = 7'b0111111;
            4'h1: s = 7'b0000110;
            4'h2: s = 7'b1011011;
            4'h3: s = 7'b1001111;
            4'h4: s = 7'b1100110;
            4'h5: s = 7'b1101101;
            4'h6: s = 7'b1111101;
            4'h7: s = 7'b0000111;
            4'h8: s = 7'b1111111;
            4'h9: s = 7'b1101111;
            4'hA: s = 7'b1110111;
            4'hB: s = 7'b1111100;
            4'hC: s = 7'b0111001;
            4'hD: s = 7'b1011110;
            4'hE: s = 7'b1111001;
            default: s = 7'b1110001;
        endcase
        return s;
    endfunction

    function automatic seg_t lit_to_drive(input seg_t lit);
        return ~lit;
    endfunction

endpackage

// File: rtl/hd_code_hold.sv
module hd_code_hold #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Clocked stand-in for a transparent latch: load while hold is low
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (!hold) begin
            q <= d;
        end
    end
endmodule

// File: rtl/hd_blank_ctl.sv
module hd_blank_ctl
    import hexdisp_pkg::*;
(
    input  code_t      code,
    input  logic       rbi_n,
    input  logic       dark,
    output blank_dec_t dec
);
    logic zero_code;
    logic ripple_hit;

    always_comb begin
        zero_code  = (code == '0);
        ripple_hit = zero_code && !rbi_n;
        dec.ripple_n = !ripple_hit;
        if (dark) begin
            dec.why = BLK_FORCE;
        end else if (ripple_hit) begin
            dec.why = BLK_RIPPLE;
        end else begin
            dec.why = BLK_NONE;
        end
    end
endmodule

// File: rtl/hd_glyph.sv
module hd_glyph
    import hexdisp_pkg::*;
(
    input  code_t      code,
    input  blank_why_e why,
    output seg_t       seg_n
);
    seg_t lit;

    always_comb begin
        lit = glyph_lit(code);
        if (why != BLK_NONE) begin
            seg_n = '1;
        end else begin
            seg_n = lit_to_drive(lit);
        end
    end
endmodule

// File: rtl/hex_digit_driver.sv
module hex_digit_driver
    import hexdisp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    input  logic              hold,
    input  logic              rbi_n,
    input  logic              force_dark,
    output logic [SEG_W-1:0]  seg_n,
    output logic              rbo_n
);
    code_t      held_code;
    blank_dec_t bdec;

    hd_code_hold #(.W(CODE_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .hold (hold),
        .d    (code_in),
        .q    (held_code)
    );

    hd_blank_ctl u_blank (
        .code  (held_code),
        .rbi_n (rbi_n),
        .dark  (force_dark),
        .dec   (bdec)
    );

    hd_glyph u_glyph (
        .code  (held_code),
        .why   (bdec.why),
        .seg_n (seg_n)
    );

    assign rbo_n = bdec.ripple_n;
endmodule

// File: rtl/hex_digit_driver_chk.sv
module hex_digit_driver_chk
    import hexdisp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] code_in,
    input logic              hold,
    input logic              rbi_n,
    input logic              force_dark,
    input logic [SEG_W-1:0]  seg_n,
    input logic              rbo_n,
    input logic [CODE_W-1:0] held
);
    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hold)) |-> (held == $past(code_in)));

    p_retain_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hold)) |-> $stable(held));

    p_ripple_dark_r6: assert property (@(posedge clk) disable iff (rst)
        !rbo_n |-> (seg_n == '1));

    p_zero_shown_r7: assert property (@(posedge clk) disable iff (rst)
        (rbi_n && !force_dark && held == '0) |-> (seg_n != '1 && rbo_n));

    p_ripple_cause_r8: assert property (@(posedge clk) disable iff (rst)
        !rbo_n |-> (!rbi_n && held == '0));

    p_force_dark_r9: assert property (@(posedge clk) disable iff (rst)
        force_dark |-> (seg_n == '1));
endmodule

bind hex_digit_driver hex_digit_driver_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .code_in    (code_in),
    .hold       (hold),
    .rbi_n      (rbi_n),
    .force_dark (force_dark),
    .seg_n      (seg_n),
    .rbo_n      (rbo_n),
    .held       (held_code)
);

// File: tb/hex_digit_driver_bench.sv
`timescale 1ns/1ps
module hex_digit_driver_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] code_in = 4'h0;
    logic       hold = 1'b0;
    logic       rbi_n = 1'b1;
    logic       force_dark = 1'b0;
    logic [6:0] seg_n;
    logic       rbo_n;

    int n_chk  = 0;
    int n_fail = 0;
    logic [3:0] m_code = 4'h0;

    always #2 clk = ~clk;

    hex_digit_driver u_hex_digit_driver (
        .clk        (clk),
        .rst        (rst),
        .code_in    (code_in),
        .hold       (hold),
        .rbi_n      (rbi_n),
        .force_dark (force_dark),
        .seg_n      (seg_n),
        .rbo_n      (rbo_n)
    );

    function automatic logic [6:0] font(input logic [3:0] c);
        logic [6:0] t [16];
        t = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
              7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[c];
    endfunction

    function automatic logic exp_rbo(input logic [3:0] c, input logic ri);
        return !(c == 4'h0 && !ri);
    endfunction

    function automatic logic [6:0] exp_seg(input logic [3:0] c, input logic ri,
                                           input logic dk);
        if (dk || !exp_rbo(c, ri)) return 7'h7F;
        return ~font(c);
    endfunction

    function automatic string tag_of(input logic [3:0] c, input logic ri,
                                     input logic dk);
        if (dk)            return "R9";
        if (c == 4'h0)     return ri ? "R7" : "R6";
        if (c < 4'd10)     return "R2";
        return "R3";
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check_out(input string tag);
        chk(tag, {1'b0, seg_n}, {1'b0, exp_seg(m_code, rbi_n, force_dark)});
        chk((m_code == 4'h0) ? tag : "R8", {7'b0, rbo_n}, {7'b0, exp_rbo(m_code, rbi_n)});
    endtask

    task automatic step(input logic [3:0] c, input logic h, input logic ri,
                        input logic dk);
        @(negedge clk);
        code_in = c; hold = h; rbi_n = ri; force_dark = dk;
        @(posedge clk);
        #1;
        if (!h) m_code = c;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        hold = 1'b1;
        #1;
        m_code = 4'h0;
        chk("R1", {1'b0, seg_n}, {1'b0, 7'h40});
        chk("R1", {7'b0, rbo_n}, 8'h01);

        step(4'h5, 1'b0, 1'b1, 1'b0); check_out("R4");
        step(4'h9, 1'b1, 1'b1, 1'b0); chk("R5", {1'b0, seg_n}, {1'b0, ~font(4'h5)});
        step(4'h0, 1'b1, 1'b0, 1'b0); chk("R5", {1'b0, seg_n}, {1'b0, ~font(4'h5)});
        check_out("R8");
        step(4'h0, 1'b0, 1'b0, 1'b0); check_out("R6");
        step(4'h0, 1'b0, 1'b1, 1'b0); check_out("R7");
        step(4'h0, 1'b0, 1'b0, 1'b1); check_out("R9");
        step(4'h7, 1'b0, 1'b0, 1'b1); check_out("R9");
        step(4'h3, 1'b0, 1'b0, 1'b0); check_out("R8");

        for (int i = 0; i < 16; i++) begin
            step(4'(i), 1'b0, 1'b1, 1'b0);
            check_out(tag_of(4'(i), 1'b1, 1'b0));
        end

        void'($urandom(32'd4711));
        for (int k = 0; k < 600; k++) begin
            logic [3:0] c;
            logic h, ri, dk;
            c  = ($urandom_range(0, 3) == 0) ? 4'h0 : 4'($urandom_range(0, 15));
            h  = ($urandom_range(0, 2) == 0);
            ri = ($urandom_range(0, 1) == 0);
            dk = ($urandom_range(0, 7) == 0);
            step(c, h, ri, dk);
            check_out(h ? "R5" : tag_of(c, ri, dk));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule